// File: doc/BRIEF.md
# Double-Buffered Gate Schedule Executor

This block drives the gate-open vector of one egress port from a time-aware gate control list. It holds configuration for two schedule tables. While one table runs, software arms the other, and the armed table takes over when the synchronized time of day reaches that table's absolute start time. The table rows sit in an external memory. The block addresses that memory through a combinational row read port: it places a table index and a row index on the port, and it receives the row's gate vector and its interval in clock cycles in the same cycle.

Each cycle of the running table starts one cycle time after the previous cycle. The cycle time is an integer number of nanoseconds plus a 32-bit binary fraction of a nanosecond, and the fractions are summed so that the cycle length does not drift. Other features are a stop after a programmed cycle count, an emergency override that forces a static gate vector, an on-demand snapshot of the current cycle's start time, and a clock-period setting. A write/read register port with 5-bit word addresses gives software access to all of them.

Top module: `gse_top`

Register map (word addresses). When addr[4]=0, addr[3] selects the table and addr[2:0] selects the field: 0 cycle ns, 1 cycle fraction, 2 start seconds, 3 start ns, 4 cycle counter, 5 last-cycle value, 6 status, 7 snapshot ns. In the status word, bit0 is pending, bit1 is in-use (read-only), bit2 is stop-after-last and bit3 is take-snapshot (write-only). When addr[4]=1, addr[2:0] selects the field: 0 control (bit0 emergency on), 1 static gate vector, 2 clock period in ns, 4 snapshot seconds of table 0, 5 snapshot seconds of table 1.

## Requirements
- R1: After reset, emergency is on, the static vector is all ones, gate_out is all ones, both status words read 0 and the period reads 10.
- R2: While emergency is on, gate_out equals the static vector. When emergency is off and a table is in use, gate_out equals the current row's gate vector.
- R3: When emergency is off and no table is in use, gate_out equals the static vector.
- R4: At the first clock at which time of day is greater than or equal to a pending table's start time, that table gets in-use set and pending cleared, the other table's in-use flag is cleared, and row 0 is shown after that clock edge.
- R5: Rows run in order. Each row holds for its interval in clocks, and an interval of 0 counts as 1. The last row is held until the cycle boundary.
- R6: When time of day reaches the next boundary (start plus cycle time), the running row is cut short, row 0 restarts and the cycle counter increments.
- R7: Each boundary adds the cycle fraction into a 32-bit accumulator, and a carry out of the accumulator lengthens that cycle by 1 ns.
- R8: Writing 0 to a table's pending bit before its start time cancels the takeover, and the running table continues.
- R9: With stop-after-last set, at the boundary where the cycle counter equals the last-cycle value, the table drops in-use.
- R10: Writing status bit3 captures the start time of the current cycle into the table's snapshot registers. The cycle counter stays readable.
- R11: The period register accepts only the values 5, 8 and 10. Any other write leaves it unchanged.
- R12: At most one table is in use at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tod_sec | input | 16 | Time of day, seconds |
| tod_ns | input | 32 | Time of day, nanoseconds |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| row_tbl | output | 1 | Row read port: table index |
| row_idx | output | 2 | Row read port: row index |
| row_gates | input | 8 | Gate vector of the addressed row |
| row_ivl | input | 16 | Interval of the addressed row in clocks |
| gate_out | output | 8 | Gate-open vector |

## Verification
A wrong row index or elapsed count shows on gate_out within one row interval, because the wrong gate vector appears at a known time-of-day sample. A wrong boundary or fraction accumulator moves row 0 by one clock. The bench detects this at the carry-extended boundary, and it also reads it from the snapshot register within one cycle time. A wrong pending or in-use state shows as an early, missed or duplicated takeover, or as gate_out falling back to the static vector at the wrong sample, and the status words confirm it.

// File: rtl/gse_pkg.sv
package gse_pkg;
  localparam int unsigned ADDR_W     = 5;
  localparam int unsigned NS_PER_SEC = 1000000000;
  localparam logic [2:0] F_CYC_NS  = 3'd0;
  localparam logic [2:0] F_CYC_FR  = 3'd1;
  localparam logic [2:0] F_ST_SEC  = 3'd2;
  localparam logic [2:0] F_ST_NS   = 3'd3;
  localparam logic [2:0] F_CNT     = 3'd4;
  localparam logic [2:0] F_LAST    = 3'd5;
  localparam logic [2:0] F_STATUS  = 3'd6;
  localparam logic [2:0] F_SNAP_NS = 3'd7;
  localparam logic [2:0] G_CTRL    = 3'd0;
  localparam logic [2:0] G_STATIC  = 3'd1;
  localparam logic [2:0] G_PERIOD  = 3'd2;
  localparam logic [2:0] G_SNAP_S0 = 3'd4;
  localparam logic [2:0] G_SNAP_S1 = 3'd5;
  localparam int unsigned SB_PEND = 0;
  localparam int unsigned SB_USE  = 1;
  localparam int unsigned SB_STOP = 2;
  localparam int unsigned SB_SNAP = 3;
endpackage

// File: rtl/gse_cfg_regs.sv
module gse_cfg_regs
  import gse_pkg::*;
#(
  parameter int unsigned GATES      = 8,
  parameter int unsigned SEC_W      = 16,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned PER_W      = 4,
  parameter int unsigned DEF_PERIOD = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [31:0]                wdata,
  output logic [1:0][31:0]           cyc_ns,
  output logic [1:0][31:0]           cyc_fr,
  output logic [1:0][SEC_W-1:0]      st_sec,
  output logic [1:0][31:0]           st_ns,
  output logic [1:0][CNT_W-1:0]      last_cyc,
  output logic                       emerg,
  output logic [GATES-1:0]           static_gates,
  output logic [PER_W-1:0]           period
);
  logic tbl_wr, glb_wr;
  assign tbl_wr = wr && !addr[4];
  assign glb_wr = wr && addr[4];

  for (genvar t = 0; t < 2; t++) begin : g_tbl
    logic sel;
    assign sel = tbl_wr && (addr[3] == t[0]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cyc_ns[t]   <= '0;
        cyc_fr[t]   <= '0;
        st_sec[t]   <= '0;
        st_ns[t]    <= '0;
        last_cyc[t] <= '0;
      end else if (sel) begin
        case (addr[2:0])
          F_CYC_NS: cyc_ns[t]   <= wdata;
          F_CYC_FR: cyc_fr[t]   <= wdata;
          F_ST_SEC: st_sec[t]   <= wdata[SEC_W-1:0];
          F_ST_NS:  st_ns[t]    <= wdata;
          F_LAST:   last_cyc[t] <= wdata[CNT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  logic per_ok;
  assign per_ok = (wdata == 32'd5) || (wdata == 32'd8) || (wdata == 32'd10);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      emerg        <= 1'b1;
      static_gates <= '1;
      period       <= PER_W'(DEF_PERIOD);
    end else if (glb_wr) begin
      case (addr[2:0])
        G_CTRL:   emerg        <= wdata[0];
        G_STATIC: static_gates <= wdata[GATES-1:0];
        G_PERIOD: if (per_ok) period <= wdata[PER_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gse_tbl_ctrl.sv
module gse_tbl_ctrl
  import gse_pkg::*;
#(
  parameter int unsigned SEC_W = 16,
  parameter int unsigned CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SEC_W-1:0]      tod_sec,
  input  logic [31:0]           tod_ns,
  input  logic                  wr,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [31:0]           wdata,
  input  logic [1:0][31:0]      cyc_ns,
  input  logic [1:0][31:0]      cyc_fr,
  input  logic [1:0][SEC_W-1:0] st_sec,
  input  logic [1:0][31:0]      st_ns,
  input  logic [1:0][CNT_W-1:0] last_cyc,
  output logic [1:0]            pend,
  output logic [1:0]            in_use,
  output logic [1:0]            stop_last,
  output logic [1:0][CNT_W-1:0] cyc_cnt,
  output logic [1:0][SEC_W-1:0] snap_sec,
  output logic [1:0][31:0]      snap_ns,
  output logic                  act,
  output logic                  new_cycle
);
  logic [1:0]            pend_n, use_n, stop_n;
  logic [1:0][CNT_W-1:0] cnt_n;
  logic [1:0][SEC_W-1:0] ssec_n;
  logic [1:0][31:0]      sns_n;
  logic                  act_n;
  logic [SEC_W-1:0]      cur_sec_q, cur_sec_n, nxt_sec_q, nxt_sec_n;
  logic [31:0]           cur_ns_q, cur_ns_n, nxt_ns_q, nxt_ns_n;
  logic [31:0]           acc_q, acc_n;

  function automatic logic t_ge(logic [SEC_W-1:0] as, logic [31:0] an,
                                logic [SEC_W-1:0] bs, logic [31:0] bn);
    return (as > bs) || ((as == bs) && (an >= bn));
  endfunction

  // base time plus cycle time, fraction folded into the accumulator
  logic [SEC_W-1:0] adv_base_sec, adv_sec;
  logic [31:0]      adv_base_ns, adv_ns, adv_cyc, adv_fr, adv_acc_in, adv_acc;
  logic [32:0]      fr_sum;
  logic [33:0]      ns_sum;
  always_comb begin
    fr_sum  = {1'b0, adv_acc_in} + {1'b0, adv_fr};
    adv_acc = fr_sum[31:0];
    ns_sum  = {2'b0, adv_base_ns} + {2'b0, adv_cyc} + {33'b0, fr_sum[32]};
    if (ns_sum >= 34'(NS_PER_SEC)) begin
      adv_ns  = 32'(ns_sum - 34'(NS_PER_SEC));
      adv_sec = adv_base_sec + 1'b1;
    end else begin
      adv_ns  = ns_sum[31:0];
      adv_sec = adv_base_sec;
    end
  end

  logic take0, take1, take, tsel, bound;
  assign take0 = pend[0] && t_ge(tod_sec, tod_ns, st_sec[0], st_ns[0]);
  assign take1 = pend[1] && t_ge(tod_sec, tod_ns, st_sec[1], st_ns[1]);
  assign take  = take0 || take1;
  assign tsel  = !take0;
  assign bound = (|in_use) && t_ge(tod_sec, tod_ns, nxt_sec_q, nxt_ns_q);

  always_comb begin
    adv_base_sec = take ? st_sec[tsel] : nxt_sec_q;
    adv_base_ns  = take ? st_ns[tsel]  : nxt_ns_q;
    adv_cyc      = take ? cyc_ns[tsel] : cyc_ns[act];
    adv_fr       = take ? cyc_fr[tsel] : cyc_fr[act];
    adv_acc_in   = take ? 32'd0        : acc_q;
  end

  always_comb begin
    pend_n = pend; use_n = in_use; stop_n = stop_last; cnt_n = cyc_cnt;
    ssec_n = snap_sec; sns_n = snap_ns; act_n = act;
    cur_sec_n = cur_sec_q; cur_ns_n = cur_ns_q;
    nxt_sec_n = nxt_sec_q; nxt_ns_n = nxt_ns_q; acc_n = acc_q;
    new_cycle = 1'b0;
    if (take) begin
      use_n        = tsel ? 2'b10 : 2'b01;
      pend_n[tsel] = 1'b0;
      act_n        = tsel;
      cur_sec_n    = st_sec[tsel];
      cur_ns_n     = st_ns[tsel];
      nxt_sec_n    = adv_sec;
      nxt_ns_n     = adv_ns;
      acc_n        = adv_acc;
      new_cycle    = 1'b1;
    end else if (bound) begin
      if (stop_last[act] && (cyc_cnt[act] == last_cyc[act])) begin
        use_n = 2'b00;
      end else begin
        cnt_n[act] = cyc_cnt[act] + 1'b1;
        cur_sec_n  = nxt_sec_q;
        cur_ns_n   = nxt_ns_q;
        nxt_sec_n  = adv_sec;
        nxt_ns_n   = adv_ns;
        acc_n      = adv_acc;
        new_cycle  = 1'b1;
      end
    end
    if (wr && !addr[4]) begin
      if (addr[2:0] == F_CNT) cnt_n[addr[3]] = wdata[CNT_W-1:0];
      if (addr[2:0] == F_STATUS) begin
        pend_n[addr[3]] = wdata[SB_PEND];
        stop_n[addr[3]] = wdata[SB_STOP];
        if (wdata[SB_SNAP]) begin
          ssec_n[addr[3]] = cur_sec_q;
          sns_n[addr[3]]  = cur_ns_q;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0; in_use <= '0; stop_last <= '0; cyc_cnt <= '0;
      snap_sec <= '0; snap_ns <= '0; act <= 1'b0;
      cur_sec_q <= '0; cur_ns_q <= '0; nxt_sec_q <= '0; nxt_ns_q <= '0;
      acc_q <= '0;
    end else begin
      pend <= pend_n; in_use <= use_n; stop_last <= stop_n; cyc_cnt <= cnt_n;
      snap_sec <= ssec_n; snap_ns <= sns_n; act <= act_n;
      cur_sec_q <= cur_sec_n; cur_ns_q <= cur_ns_n;
      nxt_sec_q <= nxt_sec_n; nxt_ns_q <= nxt_ns_n; acc_q <= acc_n;
    end
  end
endmodule

// File: rtl/gse_row_seq.sv
module gse_row_seq #(
  parameter int unsigned ROWS  = 4,
  parameter int unsigned IVL_W = 16,
  localparam int unsigned ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [IVL_W-1:0] ivl,
  output logic [ROW_W-1:0] row_idx
);
  logic [ROW_W-1:0] idx_n;
  logic [IVL_W-1:0] el_q, el_n;
  logic [IVL_W:0]   el_inc, ivl_eff;
  logic             last_row;

  always_comb begin
    last_row = (row_idx == ROW_W'(ROWS - 1));
    ivl_eff  = (ivl == '0) ? (IVL_W+1)'(1) : {1'b0, ivl};
    el_inc   = {1'b0, el_q} + 1'b1;
    idx_n    = row_idx;
    el_n     = el_q;
    if (restart) begin
      idx_n = '0;
      el_n  = '0;
    end else if (run && !last_row) begin
      if (el_inc >= ivl_eff) begin
        idx_n = row_idx + 1'b1;
        el_n  = '0;
      end else begin
        el_n = el_inc[IVL_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_idx <= '0;
      el_q    <= '0;
    end else begin
      row_idx <= idx_n;
      el_q    <= el_n;
    end
  end
endmodule

// File: rtl/gse_top.sv
module gse_top
  import gse_pkg::*;
#(
  parameter int unsigned GATES = 8,
  parameter int unsigned ROWS  = 4,
  parameter int unsigned IVL_W = 16,
  parameter int unsigned SEC_W = 16,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int unsigned PER_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEC_W-1:0]  tod_sec,
  input  logic [31:0]       tod_ns,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              row_tbl,
  output logic [ROW_W-1:0]  row_idx,
  input  logic [GATES-1:0]  row_gates,
  input  logic [IVL_W-1:0]  row_ivl,
  output logic [GATES-1:0]  gate_out
);
  logic [1:0][31:0]      cyc_ns, cyc_fr, st_ns, snap_ns;
  logic [1:0][SEC_W-1:0] st_sec, snap_sec;
  logic [1:0][CNT_W-1:0] last_cyc, cyc_cnt;
  logic [1:0]            pend, in_use, stop_last;
  logic                  emerg, act, new_cycle;
  logic [GATES-1:0]      static_gates;
  logic [PER_W-1:0]      period;

  gse_cfg_regs #(.GATES(GATES), .SEC_W(SEC_W), .CNT_W(CNT_W), .PER_W(PER_W),
                 .DEF_PERIOD(10)) i_regs (
    .clk, .rst_n, .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .cyc_ns, .cyc_fr, .st_sec, .st_ns, .last_cyc,
    .emerg, .static_gates, .period
  );

  gse_tbl_ctrl #(.SEC_W(SEC_W), .CNT_W(CNT_W)) i_ctrl (
    .clk, .rst_n, .tod_sec, .tod_ns,
    .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .cyc_ns, .cyc_fr, .st_sec, .st_ns, .last_cyc,
    .pend, .in_use, .stop_last, .cyc_cnt, .snap_sec, .snap_ns,
    .act, .new_cycle
  );

  gse_row_seq #(.ROWS(ROWS), .IVL_W(IVL_W)) i_rows (
    .clk, .rst_n, .restart(new_cycle), .run(|in_use), .ivl(row_ivl), .row_idx
  );

  assign row_tbl  = act;
  assign gate_out = (emerg || !(|in_use)) ? static_gates : row_gates;

  logic tb;
  assign tb = reg_addr[3];
  always_comb begin
    reg_rdata = '0;
    if (!reg_addr[4]) begin
      case (reg_addr[2:0])
        F_CYC_NS:  reg_rdata = cyc_ns[tb];
        F_CYC_FR:  reg_rdata = cyc_fr[tb];
        F_ST_SEC:  reg_rdata = 32'(st_sec[tb]);
        F_ST_NS:   reg_rdata = st_ns[tb];
        F_CNT:     reg_rdata = 32'(cyc_cnt[tb]);
        F_LAST:    reg_rdata = 32'(last_cyc[tb]);
        F_STATUS:  reg_rdata = 32'({stop_last[tb], in_use[tb], pend[tb]});
        F_SNAP_NS: reg_rdata = snap_ns[tb];
        default: ;
      endcase
    end else begin
      case (reg_addr[2:0])
        G_CTRL:    reg_rdata = 32'(emerg);
        G_STATIC:  reg_rdata = 32'(static_gates);
        G_PERIOD:  reg_rdata = 32'(period);
        G_SNAP_S0: reg_rdata = 32'(snap_sec[0]);
        G_SNAP_S1: reg_rdata = 32'(snap_sec[1]);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gse_checker.sv
module gse_checker #(
  parameter int unsigned GATES = 8,
  parameter int unsigned ROW_W = 2,
  parameter int unsigned PER_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       in_use,
  input logic [1:0]       pend,
  input logic             new_cycle,
  input logic [ROW_W-1:0] row_idx,
  input logic             emerg,
  input logic [GATES-1:0] static_gates,
  input logic [GATES-1:0] gate_out,
  input logic [PER_W-1:0] period
);
  AST_ONE_IN_USE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_use)); // R12
  AST_IDLE_STATIC: assert property (@(posedge clk) disable iff (!rst_n)
    (in_use == 2'b00) |-> (gate_out == static_gates)); // R3
  AST_EMERG_STATIC: assert property (@(posedge clk) disable iff (!rst_n)
    emerg |-> (gate_out == static_gates)); // R2
  AST_TAKE0_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_use[0]) |-> !pend[0]); // R4
  AST_TAKE1_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_use[1]) |-> !pend[1]); // R4
  AST_RESTART_ROW0: assert property (@(posedge clk) disable iff (!rst_n)
    new_cycle |=> (row_idx == '0)); // R6
  AST_PERIOD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (period == 4'd5) || (period == 4'd8) || (period == 4'd10)); // R11
endmodule

bind gse_top gse_checker #(.GATES(GATES), .ROW_W(ROW_W), .PER_W(PER_W)) i_chk (
  .clk, .rst_n, .in_use, .pend, .new_cycle, .row_idx,
  .emerg, .static_gates, .gate_out, .period
);

// File: tb/test_gse_top.sv
module test_gse_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tod_sec = '0;
  logic [31:0] tod_ns = '0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        row_tbl;
  logic [1:0]  row_idx;
  logic [7:0]  row_gates;
  logic [15:0] row_ivl;
  logic [7:0]  gate_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0]  mem_g [2][4];
  logic [15:0] mem_i [2][4];
  assign row_gates = mem_g[row_tbl][row_idx];
  assign row_ivl   = mem_i[row_tbl][row_idx];

  gse_top i_gse_top (.*);

  always #5 clk = ~clk;
  always @(posedge clk) tod_ns <= tod_ns + 32'd10;

  typedef struct { int unsigned t; logic [7:0] g; string tag; } exp_t;
  exp_t q[$];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_at(int unsigned t, logic [7:0] g, string tag);
    exp_t e;
    e.t = t; e.g = g; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compares gate_out at the scheduled time-of-day samples
  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      if (tod_ns == q[0].t) begin
        check(q[0].tag, 32'(gate_out), 32'(q[0].g));
        void'(q.pop_front());
      end else if (tod_ns > q[0].t) begin
        check({q[0].tag, " missed"}, 32'(tod_ns), 32'(q[0].t));
        void'(q.pop_front());
      end
    end
  end

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    reg_addr = a;
    #1 check(tag, reg_rdata, exp);
  endtask

  task automatic wait_tod(int unsigned v);
    while (tod_ns < v) @(negedge clk);
  endtask

  task automatic arm(bit t, int unsigned cyc, int unsigned fr, int unsigned st,
                     int unsigned last, logic [31:0] status);
    wr({1'b0, t, 3'd0}, cyc);
    wr({1'b0, t, 3'd1}, fr);
    wr({1'b0, t, 3'd2}, 32'd0);
    wr({1'b0, t, 3'd3}, st);
    wr({1'b0, t, 3'd4}, 32'd0);
    wr({1'b0, t, 3'd5}, last);
    wr({1'b0, t, 3'd6}, status);
  endtask

  initial begin
    mem_g[0][0] = 8'h01; mem_i[0][0] = 16'd3;
    mem_g[0][1] = 8'h02; mem_i[0][1] = 16'd2;
    mem_g[0][2] = 8'h04; mem_i[0][2] = 16'd4;
    mem_g[0][3] = 8'h08; mem_i[0][3] = 16'd1;
    mem_g[1][0] = 8'h10; mem_i[1][0] = 16'd2;
    mem_g[1][1] = 8'h20; mem_i[1][1] = 16'd0;
    mem_g[1][2] = 8'h40; mem_i[1][2] = 16'd2;
    mem_g[1][3] = 8'h80; mem_i[1][3] = 16'd2;
    // table 1 row 1 has interval 0, which counts as 1: rows at k=0-1, 2, 3-4, 5+
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset gate_out", 32'(gate_out), 32'hFF);
    rd(5'h10, 32'd1, "R1 reset emergency on");
    rd(5'h06, 32'd0, "R1 reset status0");
    rd(5'h0E, 32'd0, "R1 reset status1");
    rd(5'h12, 32'd10, "R1 reset period");

    wr(5'h12, 32'd8);
    rd(5'h12, 32'd8, "R11 period 8 accepted");
    wr(5'h12, 32'd7);
    rd(5'h12, 32'd8, "R11 period 7 rejected");

    wr(5'h11, 32'hA5);
    check("R2 emergency static", 32'(gate_out), 32'hA5);
    wr(5'h10, 32'd0);
    check("R3 idle static", 32'(gate_out), 32'hA5);

    // table 0: start 2000, cycle 200 ns; table 1 takes over at 3000, cycle 50 ns
    expect_at(2000, 8'hA5, "R4 before start");
    expect_at(2010, 8'h01, "R4 row0 at takeover");
    expect_at(2030, 8'h01, "R5 row0 held 3 clocks");
    expect_at(2040, 8'h02, "R5 row1");
    expect_at(2060, 8'h04, "R5 row2");
    expect_at(2100, 8'h08, "R5 row3");
    expect_at(2200, 8'h08, "R5 last row held");
    expect_at(2210, 8'h01, "R6 boundary row0");
    expect_at(2990, 8'h08, "R5 table0 last row");
    expect_at(3010, 8'h10, "R4 table1 row0");
    expect_at(3030, 8'h20, "R5 zero interval row");
    expect_at(3040, 8'h40, "R5 row after zero interval");
    expect_at(3050, 8'h40, "R6 row2 before cut");
    expect_at(3060, 8'h10, "R6 row cut short");
    arm(1'b0, 200, 0, 2000, 0, 32'd1);
    rd(5'h06, 32'd1, "R4 pending reported");
    arm(1'b1, 50, 0, 3000, 0, 32'd1);
    wait_tod(3100);
    rd(5'h06, 32'd0, "R4 old table released");
    rd(5'h0E, 32'd2, "R4 new table in use");

    // cancel
    arm(1'b0, 200, 0, 5000, 0, 32'd1);
    wait_tod(4500);
    wr(5'h06, 32'd0);
    expect_at(5050, 8'h40, "R8 table1 continues");
    expect_at(5210, 8'h10, "R8 table1 continues row0");
    wait_tod(5300);
    rd(5'h06, 32'd0, "R8 cancelled table idle");
    rd(5'h0E, 32'd2, "R8 running table in use");

    // stop after last cycle (cycles 0,1,2)
    arm(1'b0, 200, 0, 6000, 2, 32'd5);
    expect_at(6410, 8'h01, "R6 third cycle row0");
    expect_at(6590, 8'h08, "R9 last cycle still running");
    expect_at(6610, 8'hA5, "R9 stopped to static");
    wait_tod(6700);
    rd(5'h06, 32'd4, "R9 status after stop");
    rd(5'h0E, 32'd0, "R9 table1 released");
    rd(5'h04, 32'd2, "R9 cycle count");

    // fractional cycle time: boundaries 8100, 8201, 8301, 8402
    arm(1'b1, 100, 32'h8000_0000, 8000, 0, 32'd1);
    expect_at(8110, 8'h10, "R6 frac first boundary");
    expect_at(8210, 8'h80, "R7 carry extends cycle");
    expect_at(8220, 8'h10, "R7 boundary after carry");
    wait_tod(8350);
    wr(5'h0E, 32'd8);
    rd(5'h0F, 32'd8301, "R10 snapshot ns");
    rd(5'h15, 32'd0, "R10 snapshot sec");
    rd(5'h0C, 32'd3, "R10 cycle count");

    wait_tod(8600);
    wr(5'h10, 32'd1);
    check("R2 emergency overrides schedule", 32'(gate_out), 32'hA5);
    wr(5'h10, 32'd0);
    wait_tod(8700);
    check("R2 schedule drives after emergency off", 32'(q.size()), 32'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule